// File: doc/BRIEF.md
# Byte-Coded Flash Programming Sequencer

This block runs a compact byte program against a serial-flash controller so that a whole page program, sector erase or status wait completes without a host stepping through it. Software places the program in a local byte buffer and pulses `start`. The sequencer then walks the buffer from address zero and carries out each opcode. Depending on the opcode it pushes bytes into the controller's transmit FIFO, waits for the transmit watermark, writes controller registers, changes the transfer direction, or runs a complete busy-status poll of the flash.

The program buffer is read through a combinational port: `prog_data` must show the byte at `prog_addr` in the same cycle. On the controller side the block drives single-cycle strobes: a FIFO push, a register write, a direction write and a receive pop. When the program ends, `done` rises and holds until the next start. `error` rises together with `done` when the program holds an unknown opcode or a busy poll runs out of tries.

Top module: `bseq_top`

## Requirements
- R1: After reset, `done` and `error` are 0 and none of `tx_push`, `reg_wr`, `dir_wr` or `rx_pop` is asserted until `start` is pulsed.
- R2: Opcode 0x04 ends the program. `done` is set with `error` clear, and no further strobe is issued until the next start.
- R3: Opcode 0x08 is followed by a count byte N (0 to 255) and then N payload bytes. Each payload byte is pushed once, in buffer order. N = 0 pushes nothing and execution continues at the next opcode.
- R4: `tx_push` is never asserted while `tx_full` is high. A pending push waits until `tx_full` drops.
- R5: Opcode 0x0C stalls the program until `txwm_pend` is high. No strobe is issued while it waits.
- R6: Opcode 0x10 is followed by an offset byte and a data byte. It issues one `reg_wr` carrying that offset on `reg_addr` and that data on `reg_wdata`.
- R7: Opcode 0x18 is followed by one argument byte. It issues one `dir_wr`, and `dir_val` equals bit 3 of that argument (1 = transmit, 0 = receive).
- R8: Opcode 0x14 runs this fixed sequence: a register write of value 0x02 (chip select held) to offset 0x18; a push of 0x05; one pop whose byte is discarded; then repeated pairs of a 0x00 push and a pop, until a popped byte has bit 0 (busy) clear; and finally a register write of value 0x00 (chip select automatic) to offset 0x18. A pop happens only while `rx_valid` is high.
- R9: If `max(poll_limit,1)` consecutive polled bytes all show busy, the poll stops. The chip-select release write is still issued, and then `done` and `error` are both set.
- R10: Any opcode other than 0x04, 0x08, 0x0C, 0x10, 0x14 or 0x18 stops execution at once, with `done` and `error` both set and no strobe for that opcode.
- R11: A `start` pulse while a program is running has no effect. A `start` pulse while idle clears `done` and `error` and restarts from buffer address 0.
- R12: At most one of `tx_push`, `reg_wr` and `dir_wr` is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin executing the program at address 0 (honoured only when idle) |
| prog_addr | output | PROG_AW | Program buffer read address |
| prog_data | input | 8 | Program byte at `prog_addr`, valid in the same cycle |
| tx_full | input | 1 | Controller transmit FIFO is full |
| tx_push | output | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| txwm_pend | input | 1 | Transmit watermark pending flag |
| rx_valid | input | 1 | Receive FIFO holds a byte |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_pop | output | 1 | Remove the head receive byte |
| reg_wr | output | 1 | Controller register write strobe |
| reg_addr | output | 8 | Register offset for `reg_wr` |
| reg_wdata | output | 8 | Register data for `reg_wr` |
| dir_wr | output | 1 | Write the direction field |
| dir_val | output | 1 | Direction value (1 transmit, 0 receive) |
| poll_limit | input | TMO_W | Maximum busy status reads per poll |
| done | output | 1 | Program finished (held until next start) |
| error | output | 1 | Finished on an unknown opcode or poll timeout |

## Verification
The checker enforces on every cycle the properties that are local in time. These are: no push while the FIFO is full, no pop without a valid receive byte, at most one strobe in a cycle, silence once `done` is up, `error` only together with `done`, and the flags staying clear while a program runs. What no single cycle can show is left to the bench. It checks the order and contents of the strobe stream across opcodes, the discarded first status byte, the loop exit on a clear busy bit, the exact number of polls before a timeout, and whether a mid-run start is ignored. The bench compares that stream against a model that executes the same program, under random FIFO-full and watermark timing.

// File: rtl/bseq_pkg.sv
// Package: shared opcode values, state and opcode-class types for the
// byte-coded flash sequencer. Assumes 8-bit program bytes.
package bseq_pkg;

    localparam logic [7:0] OPC_END  = 8'h04;
    localparam logic [7:0] OPC_TX   = 8'h08;
    localparam logic [7:0] OPC_WM   = 8'h0C;
    localparam logic [7:0] OPC_WREG = 8'h10;
    localparam logic [7:0] OPC_WIP  = 8'h14;
    localparam logic [7:0] OPC_DIR  = 8'h18;

    localparam int DIR_BIT  = 3;   // direction bit inside the 0x18 argument
    localparam int BUSY_BIT = 0;   // busy flag inside the status byte

    typedef enum logic [2:0] {
        OPK_END, OPK_TX, OPK_WM, OPK_WREG, OPK_WIP, OPK_DIR, OPK_BAD
    } opk_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_TXCNT, ST_TXDAT, ST_WMWAIT, ST_RADDR,
        ST_RDATA, ST_DIRARG, ST_WHOLD, ST_WCMD, ST_WDISC, ST_WPOLL,
        ST_WCHK, ST_WREL
    } seq_state_t;

endpackage

// File: rtl/bseq_opdec.sv
// Opcode classifier: maps a raw program byte onto an opcode class.
// Purely combinational; any byte outside the defined set is OPK_BAD.
module bseq_opdec
    import bseq_pkg::*;
(
    input  logic [7:0] op_byte,
    output opk_t       op_kind
);

    // classify the fetched byte
    always_comb begin
        unique case (op_byte)
            OPC_END:  op_kind = OPK_END;
            OPC_TX:   op_kind = OPK_TX;
            OPC_WM:   op_kind = OPK_WM;
            OPC_WREG: op_kind = OPK_WREG;
            OPC_WIP:  op_kind = OPK_WIP;
            OPC_DIR:  op_kind = OPK_DIR;
            default:  op_kind = OPK_BAD;
        endcase
    end

endmodule

// File: rtl/bseq_poll_timer.sv
// Busy-poll attempt counter. Cleared at the start of a poll and stepped
// after each busy reading. 'expired' says the current busy reading is
// the last one allowed (limit 0 behaves as limit 1).
module bseq_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_plus;

    // count busy readings since the poll began
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    // compare the would-be reading count against the limit
    always_comb begin
        cnt_plus = {1'b0, cnt_q} + 1'b1;
        expired  = (cnt_plus >= {1'b0, limit});
    end

endmodule

// File: rtl/bseq_top.sv
// Byte-coded flash programming sequencer (top).
// Walks a byte program from address 0 and drives a serial-flash
// controller through push, register-write, direction and pop strobes.
// Assumes a combinational program read port and that the controller
// delivers one receive byte per pushed byte while in receive direction.
module bseq_top
    import bseq_pkg::*;
#(
    parameter int         PROG_AW    = 8,
    parameter int         TMO_W      = 16,
    parameter logic [7:0] CSMODE_OFS = 8'h18,
    parameter logic [7:0] CS_HOLD    = 8'h02,
    parameter logic [7:0] CS_AUTO    = 8'h00,
    parameter logic [7:0] RDSR_CMD   = 8'h05
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic [PROG_AW-1:0] prog_addr,
    input  logic [7:0]         prog_data,
    input  logic               tx_full,
    output logic               tx_push,
    output logic [7:0]         tx_byte,
    input  logic               txwm_pend,
    input  logic               rx_valid,
    input  logic [7:0]         rx_data,
    output logic               rx_pop,
    output logic               reg_wr,
    output logic [7:0]         reg_addr,
    output logic [7:0]         reg_wdata,
    output logic               dir_wr,
    output logic               dir_val,
    input  logic [TMO_W-1:0]   poll_limit,
    output logic               done,
    output logic               error
);

    localparam logic [7:0] POLL_FILL = 8'h00;

    seq_state_t         state_q, state_d;
    logic [PROG_AW-1:0] pc_q;
    logic [7:0]         cnt_q;
    logic [7:0]         raddr_q;
    logic               done_q, err_q, tmo_q;

    opk_t op_kind;
    logic pc_zero, pc_inc, ld_cnt, dec_cnt, ld_raddr;
    logic set_done, set_err, set_tmo, clr_flags;
    logic tmr_clr, tmr_step, tmr_exp;

    bseq_opdec u_dec (
        .op_byte (prog_data),
        .op_kind (op_kind)
    );

    bseq_poll_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .step    (tmr_step),
        .limit   (poll_limit),
        .expired (tmr_exp)
    );

    // next-state and strobe decode
    always_comb begin
        state_d   = state_q;
        pc_zero   = 1'b0;
        pc_inc    = 1'b0;
        ld_cnt    = 1'b0;
        dec_cnt   = 1'b0;
        ld_raddr  = 1'b0;
        set_done  = 1'b0;
        set_err   = 1'b0;
        set_tmo   = 1'b0;
        clr_flags = 1'b0;
        tmr_clr   = 1'b0;
        tmr_step  = 1'b0;
        tx_push   = 1'b0;
        tx_byte   = 8'h00;
        rx_pop    = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = 8'h00;
        reg_wdata = 8'h00;
        dir_wr    = 1'b0;
        dir_val   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    clr_flags = 1'b1;
                    pc_zero   = 1'b1;
                    state_d   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                unique case (op_kind)
                    OPK_END: begin
                        set_done = 1'b1;
                        state_d  = ST_IDLE;
                    end
                    OPK_TX:   begin pc_inc = 1'b1; state_d = ST_TXCNT;  end
                    OPK_WM:   begin pc_inc = 1'b1; state_d = ST_WMWAIT; end
                    OPK_WREG: begin pc_inc = 1'b1; state_d = ST_RADDR;  end
                    OPK_WIP:  begin pc_inc = 1'b1; state_d = ST_WHOLD;  end
                    OPK_DIR:  begin pc_inc = 1'b1; state_d = ST_DIRARG; end
                    default: begin
                        set_done = 1'b1;
                        set_err  = 1'b1;
                        state_d  = ST_IDLE;
                    end
                endcase
            end
            ST_TXCNT: begin
                pc_inc  = 1'b1;
                ld_cnt  = 1'b1;
                state_d = (prog_data == 8'h00) ? ST_FETCH : ST_TXDAT;
            end
            ST_TXDAT: begin
                if (!tx_full) begin
                    tx_push = 1'b1;
                    tx_byte = prog_data;
                    pc_inc  = 1'b1;
                    dec_cnt = 1'b1;
                    if (cnt_q == 8'd1) state_d = ST_FETCH;
                end
            end
            ST_WMWAIT: begin
                if (txwm_pend) state_d = ST_FETCH;
            end
            ST_RADDR: begin
                ld_raddr = 1'b1;
                pc_inc   = 1'b1;
                state_d  = ST_RDATA;
            end
            ST_RDATA: begin
                reg_wr    = 1'b1;
                reg_addr  = raddr_q;
                reg_wdata = prog_data;
                pc_inc    = 1'b1;
                state_d   = ST_FETCH;
            end
            ST_DIRARG: begin
                dir_wr  = 1'b1;
                dir_val = prog_data[DIR_BIT];
                pc_inc  = 1'b1;
                state_d = ST_FETCH;
            end
            ST_WHOLD: begin
                reg_wr    = 1'b1;
                reg_addr  = CSMODE_OFS;
                reg_wdata = CS_HOLD;
                state_d   = ST_WCMD;
            end
            ST_WCMD: begin
                if (!tx_full) begin
                    tx_push = 1'b1;
                    tx_byte = RDSR_CMD;
                    state_d = ST_WDISC;
                end
            end
            ST_WDISC: begin
                if (rx_valid) begin
                    rx_pop  = 1'b1;
                    tmr_clr = 1'b1;
                    state_d = ST_WPOLL;
                end
            end
            ST_WPOLL: begin
                if (!tx_full) begin
                    tx_push = 1'b1;
                    tx_byte = POLL_FILL;
                    state_d = ST_WCHK;
                end
            end
            ST_WCHK: begin
                if (rx_valid) begin
                    rx_pop = 1'b1;
                    if (!rx_data[BUSY_BIT]) begin
                        state_d = ST_WREL;
                    end else if (tmr_exp) begin
                        set_tmo = 1'b1;
                        state_d = ST_WREL;
                    end else begin
                        tmr_step = 1'b1;
                        state_d  = ST_WPOLL;
                    end
                end
            end
            ST_WREL: begin
                reg_wr    = 1'b1;
                reg_addr  = CSMODE_OFS;
                reg_wdata = CS_AUTO;
                if (tmo_q) begin
                    set_done = 1'b1;
                    set_err  = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    state_d  = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // program counter
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_zero) pc_q <= '0;
        else if (pc_inc)  pc_q <= pc_q + 1'b1;
    end

    // payload byte counter for the push opcode
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= 8'h00;
        else if (ld_cnt)  cnt_q <= prog_data;
        else if (dec_cnt) cnt_q <= cnt_q - 8'd1;
    end

    // latched register offset for the register-write opcode
    always_ff @(posedge clk) begin
        if (!rst_n)        raddr_q <= 8'h00;
        else if (ld_raddr) raddr_q <= prog_data;
    end

    // completion, error and poll-timeout flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (clr_flags) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            if (set_done) done_q <= 1'b1;
            if (set_err)  err_q  <= 1'b1;
            if (set_tmo)  tmo_q  <= 1'b1;
        end
    end

    assign prog_addr = pc_q;
    assign done      = done_q;
    assign error     = err_q;

endmodule

// File: rtl/bseq_checker.sv
// Checker: cycle-level properties of the sequencer's port behaviour.
// Bound to bseq_top; observes ports only.
module bseq_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tx_full,
    input logic tx_push,
    input logic rx_valid,
    input logic rx_pop,
    input logic reg_wr,
    input logic dir_wr,
    input logic done,
    input logic error
);

    // R4: never push into a full FIFO
    a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    // R8: pops only with a byte present
    a_r8_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_valid);

    // R12: one strobe at a time
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_push, reg_wr, dir_wr}));

    // R2: finished sequencer stays silent
    a_r2_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(tx_push || reg_wr || dir_wr || rx_pop));

    // R10: error is only reported together with done
    a_r10_error_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R11: an accepted start clears both flags on the next cycle
    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start && done) |=> (!done && !error));

endmodule

bind bseq_top bseq_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tx_full  (tx_full),
    .tx_push  (tx_push),
    .rx_valid (rx_valid),
    .rx_pop   (rx_pop),
    .reg_wr   (reg_wr),
    .dir_wr   (dir_wr),
    .done     (done),
    .error    (error)
);

// File: tb/bseq_top_tb.sv
module bseq_top_tb;

    localparam int AW = 8;
    localparam int TW = 16;
    localparam int MAXEV = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] prog_addr;
    logic [7:0] prog_data;
    logic tx_full = 1'b0, txwm_pend = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic tx_push, rx_pop, reg_wr, dir_wr, dir_val, done, error;
    logic [7:0] tx_byte, reg_addr, reg_wdata;
    logic [TW-1:0] poll_limit = 16'd10;

    logic [7:0] mem [256];
    assign prog_data = mem[prog_addr];

    bseq_top #(.PROG_AW(AW), .TMO_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .tx_full(tx_full), .tx_push(tx_push), .tx_byte(tx_byte),
        .txwm_pend(txwm_pend),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .dir_wr(dir_wr), .dir_val(dir_val),
        .poll_limit(poll_limit), .done(done), .error(error)
    );

    always #10 clk = ~clk;   // 50 MHz

    int total = 0, bad = 0;
    int busy_cfg = 0, busy_left = 0;
    bit full_rand = 0, wm_hold = 0, dir_rx = 0;

    // event logs: kind 0 push, 1 register write, 2 direction write
    int act_n, exp_n;
    int act_k [MAXEV]; int act_a [MAXEV]; int act_b [MAXEV];
    int exp_k [MAXEV]; int exp_a [MAXEV]; int exp_b [MAXEV];
    bit exp_err;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // controller and flash model, updated at the active edge
    always @(posedge clk) begin
        tx_full   <= full_rand ? ($urandom % 3 == 0) : 1'b0;
        txwm_pend <= wm_hold ? 1'b0 : ($urandom % 2 == 1);
        if (dir_wr) dir_rx <= !dir_val;
        if (rx_pop) rx_valid <= 1'b0;
        if (tx_push && dir_rx) begin
            rx_valid <= 1'b1;
            if (tx_byte == 8'h05) rx_data <= 8'hFF;
            else if (busy_left > 0) begin
                rx_data   <= 8'($urandom) | 8'h01;
                busy_left <= busy_left - 1;
            end else rx_data <= 8'($urandom) & 8'hFE;
        end
    end

    // monitor: log strobes mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_push && tx_full) chk(0, "R4 push while full", 1, 0);
            if (tx_push && act_n < MAXEV) begin
                act_k[act_n] = 0; act_a[act_n] = tx_byte; act_b[act_n] = 0; act_n++;
            end
            if (reg_wr && act_n < MAXEV) begin
                act_k[act_n] = 1; act_a[act_n] = reg_addr; act_b[act_n] = reg_wdata; act_n++;
            end
            if (dir_wr && act_n < MAXEV) begin
                act_k[act_n] = 2; act_a[act_n] = dir_val; act_b[act_n] = 0; act_n++;
            end
        end
    end

    task automatic ex(input int k, input int a, input int b);
        exp_k[exp_n] = k; exp_a[exp_n] = a; exp_b[exp_n] = b; exp_n++;
    endtask

    // reference executor of the byte program
    task automatic build_expected();
        int pc = 0;
        bit run = 1;
        exp_n = 0; exp_err = 0;
        while (run) begin
            int op = mem[pc[7:0]];
            pc++;
            case (op)
                8'h04: run = 0;
                8'h08: begin
                    int n = mem[pc[7:0]]; pc++;
                    for (int i = 0; i < n; i++) begin ex(0, mem[pc[7:0]], 0); pc++; end
                end
                8'h0C: ;
                8'h10: begin ex(1, mem[pc[7:0]], mem[(pc+1) & 255]); pc += 2; end
                8'h18: begin ex(2, mem[pc[7:0]][3], 0); pc++; end
                8'h14: begin
                    int lim = (poll_limit == 0) ? 1 : int'(poll_limit);
                    ex(1, 8'h18, 8'h02); ex(0, 8'h05, 0);
                    for (int k = 0; ; k++) begin
                        ex(0, 8'h00, 0);
                        if (k >= busy_cfg) break;
                        if (k + 1 >= lim) begin exp_err = 1; break; end
                    end
                    ex(1, 8'h18, 8'h00);
                    if (exp_err) run = 0;
                end
                default: begin exp_err = 1; run = 0; end
            endcase
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // run program, compare strobe log and flags
    task automatic run_check(input string tag);
        int wd = 0;
        build_expected();
        busy_left = busy_cfg;
        act_n = 0;
        pulse_start();
        while (!done && wd < 20000) begin @(negedge clk); wd++; end
        chk(wd < 20000, {tag, " watchdog"}, wd, 20000);
        repeat (3) @(negedge clk);
        chk(act_n == exp_n, {tag, " event count"}, act_n, exp_n);
        for (int i = 0; i < exp_n && i < act_n; i++) begin
            chk(act_k[i] == exp_k[i] && act_a[i] == exp_a[i] && act_b[i] == exp_b[i],
                {tag, " event"}, (act_k[i] << 16) | (act_a[i] << 8) | act_b[i],
                (exp_k[i] << 16) | (exp_a[i] << 8) | exp_b[i]);
        end
        chk(done == 1'b1, {tag, " done"}, done, 1);
        chk(error == exp_err, {tag, " error"}, error, exp_err);
    endtask

    int p;
    task automatic put(input int b); mem[p[7:0]] = 8'(b); p++; endtask

    task automatic page_prog(input int n, input int addr);
        p = 0;
        put(8'h18); put(8'h08);
        put(8'h08); put(1); put(8'h06);
        put(8'h0C);
        put(8'h10); put(8'h18); put(8'h02);
        put(8'h08); put(4 + n); put(8'h02); put(addr >> 16); put(addr >> 8); put(addr);
        for (int i = 0; i < n; i++) put($urandom);
        put(8'h0C);
        put(8'h10); put(8'h18); put(8'h00);
        put(8'h18); put(8'h00);
        put(8'h14);
        put(8'h18); put(8'h08);
        put(8'h04);
    endtask

    initial begin
        bit seen;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) mem[i] = 8'h04;
        act_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(!done && !error, "R1 flags after reset", {done, error}, 0);
        chk(act_n == 0 && !rx_pop, "R1 no strobes", act_n, 0);

        // R2: empty program
        p = 0; put(8'h04);
        run_check("R2 end only");

        // R3/R6/R7: directed mix incl. zero count
        p = 0; put(8'h08); put(0); put(8'h10); put(8'h2C); put(8'hA5);
        put(8'h18); put(8'h08); put(8'h18); put(8'hF7);
        put(8'h08); put(3); put(8'h11); put(8'h22); put(8'h33); put(8'h04);
        run_check("R3 R6 R7 directed");

        // R10: unknown opcode stops
        p = 0; put(8'h08); put(1); put(8'hAA); put(8'h07); put(8'h08); put(1); put(8'hBB); put(8'h04);
        run_check("R10 bad opcode");

        // R11: start after error clears flags
        p = 0; put(8'h04);
        run_check("R11 restart clears");

        // R5: watermark wait stalls the next strobe
        p = 0; put(8'h0C); put(8'h10); put(8'h40); put(8'h3C); put(8'h04);
        wm_hold = 1; act_n = 0; build_expected();
        pulse_start();
        repeat (20) @(negedge clk);
        chk(act_n == 0, "R5 stalled while watermark low", act_n, 0);
        wm_hold = 0;
        repeat (10) @(negedge clk);
        chk(act_n == 1 && act_k[0] == 1 && act_a[0] == 8'h40 && act_b[0] == 8'h3C,
            "R5 write after watermark", act_n, 1);

        // R11: start while running is ignored
        p = 0; put(8'h08); put(1); put(8'h11); put(8'h0C); put(8'h08); put(1); put(8'h22); put(8'h04);
        wm_hold = 1; act_n = 0;
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        repeat (5) @(negedge clk);
        wm_hold = 0;
        repeat (15) @(negedge clk);
        chk(act_n == 2 && act_a[0] == 8'h11 && act_a[1] == 8'h22, "R11 mid-run start ignored", act_n, 2);
        chk(done && !error, "R11 done after ignored start", done, 1);

        // R8: poll with busy readings
        busy_cfg = 3; poll_limit = 16'd10;
        p = 0; put(8'h18); put(8'h00); put(8'h14); put(8'h04);
        run_check("R8 busy poll");

        // R9: timeout after limit busy readings
        busy_cfg = 100; poll_limit = 16'd3;
        run_check("R9 poll timeout");
        poll_limit = 16'd0;
        run_check("R9 zero limit");

        // R4: stalls on full FIFO, random page programs
        full_rand = 1; poll_limit = 16'd10;
        for (int it = 0; it < 30; it++) begin
            busy_cfg = $urandom % 5;
            page_prog(1 + $urandom % 40, $urandom & 24'hFFFFFF);
            run_check("R3 R4 R8 random page program");
        end
        full_rand = 0;

        // R2: silence after done
        act_n = 0;
        repeat (20) @(negedge clk);
        seen = (act_n != 0);
        chk(!seen, "R2 silent after done", act_n, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule